// File: doc/BRIEF.md
# Hit Conditioning and Logical Pad Merger

This block sits behind sixteen discriminator channels of a detector front end. Every binary hit line is first aligned in time by a per-line delay that counts whole clock cycles. It then goes through a digital shaper that turns each rising edge into a pulse of programmable length, and past a per-line suppress bit. The conditioned lines are then merged by OR into eight logical pad outputs. The grouping is chosen at run time: neighbouring pairs, groups of four, or groups of eight.

A rate monitor watches the raw hit on one chosen input line. It counts rising edges over a repeating window of programmable length and holds the count of the last finished window for read-out. All settings sit in a small register bank behind a synchronous write/read port. Everything runs on one sampling clock with a synchronous reset.

Top module: `hit_pad_merger`

## Requirements
- R1: A synchronous reset sets every setting to zero: suppress bits, grouping, delays, pulse length, monitor select, window and the held rate. All pad outputs are low after reset.
- R2: A write with `cfg_we` high updates its register on that clock edge, and `cfg_rdata` shows it from then on. The address map is: 0 suppress bits [15:0], 1 grouping [1:0], 2 pulse length [3:0], 3 monitor select [3:0], 4 window [15:0], 5 held rate [7:0] (read only), and 8 to 11 delays. Address 8+k holds the delays of inputs 4k to 4k+3, with input 4k+j at bits [4j+3:4j]. Unused addresses read zero.
- R3: With delay value N (0 to 15), a rising hit first sampled at clock edge e raises the pad output just after edge e+N+1.
- R4: Each accepted rising edge gives a pulse of exactly (pulse length + 1) cycles, whatever the input width. Rising edges that arrive while that pulse is active are ignored.
- R5: An input whose suppress bit is 1 has no effect on any pad output.
- R6: Grouping 0, and also 3, drives output k with the OR of inputs 2k and 2k+1.
- R7: Grouping 1 drives output k (k = 0 to 3) with the OR of inputs 4k to 4k+3, and drives outputs 4 to 7 low.
- R8: Grouping 2 drives output k (k = 0 to 1) with the OR of inputs 8k to 8k+7, and drives outputs 2 to 7 low.
- R9: The monitor counts rising edges of the raw selected input over a window of (window value + 1) cycles. At the last cycle of a window it moves the count into the held-rate register and starts again from zero.
- R10: The rate counter stops at 255 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | 16 | Discriminator hit lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` (combinational) |
| hit_out | output | 8 | Logical pad outputs |

## Verification
A pad output is due N+1 edges after the edge that first samples a rising hit. A register write is readable just after its own edge, and the held rate changes just after the edge that closes a window. The bench runs a cycle model that advances on every rising edge from the same inputs the design sees. It compares the pad outputs and the read data half a cycle later, so each result is sampled in the cycle it is due. Directed sequences count the edges explicitly for the delay, dead-time, suppress and saturation cases.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_MASK  = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_WIDTH = 4'd2;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'd3;
    localparam logic [ADDR_W-1:0] A_WIN   = 4'd4;
    localparam logic [ADDR_W-1:0] A_RATE  = 4'd5;
    localparam logic [ADDR_W-1:0] A_DLY0  = 4'd8;

    typedef enum logic [1:0] {
        GRP_PAIR = 2'd0,
        GRP_QUAD = 2'd1,
        GRP_OCT  = 2'd2,
        GRP_ALT  = 2'd3
    } grp_e;
endpackage

// File: rtl/hpm_cfg_bank.sv
module hpm_cfg_bank
    import hpm_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int DLY_W = 4,
    parameter int WID_W = 4,
    parameter int TIM_W = 16,
    parameter int CNT_W = 8,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    input  logic [CNT_W-1:0]                rate,
    output logic [N_IN-1:0]                 mask,
    output grp_e                            mode,
    output logic [WID_W-1:0]                width,
    output logic [SEL_W-1:0]                sel,
    output logic [TIM_W-1:0]                win,
    output logic [N_IN-1:0][DLY_W-1:0]      dly
);
    localparam int PER_WORD = DATA_W / DLY_W;

    typedef struct packed {
        logic [N_IN-1:0]            mask;
        grp_e                       mode;
        logic [WID_W-1:0]           width;
        logic [SEL_W-1:0]           sel;
        logic [TIM_W-1:0]           win;
        logic [N_IN-1:0][DLY_W-1:0] dly;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == A_MASK)  cfg_d.mask  = wdata[N_IN-1:0];
            if (addr == A_MODE)  cfg_d.mode  = grp_e'(wdata[1:0]);
            if (addr == A_WIDTH) cfg_d.width = wdata[WID_W-1:0];
            if (addr == A_SEL)   cfg_d.sel   = wdata[SEL_W-1:0];
            if (addr == A_WIN)   cfg_d.win   = wdata[TIM_W-1:0];
            for (int c = 0; c < N_IN; c++) begin
                if (addr == A_DLY0 + ADDR_W'(c / PER_WORD))
                    cfg_d.dly[c] = wdata[(c % PER_WORD)*DLY_W +: DLY_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MASK)  rdata[N_IN-1:0]  = cfg_q.mask;
        if (addr == A_MODE)  rdata[1:0]       = cfg_q.mode;
        if (addr == A_WIDTH) rdata[WID_W-1:0] = cfg_q.width;
        if (addr == A_SEL)   rdata[SEL_W-1:0] = cfg_q.sel;
        if (addr == A_WIN)   rdata[TIM_W-1:0] = cfg_q.win;
        if (addr == A_RATE)  rdata[CNT_W-1:0] = rate;
        for (int c = 0; c < N_IN; c++) begin
            if (addr == A_DLY0 + ADDR_W'(c / PER_WORD))
                rdata[(c % PER_WORD)*DLY_W +: DLY_W] = cfg_q.dly[c];
        end
    end

    assign mask  = cfg_q.mask;
    assign mode  = cfg_q.mode;
    assign width = cfg_q.width;
    assign sel   = cfg_q.sel;
    assign win   = cfg_q.win;
    assign dly   = cfg_q.dly;

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we) && $past(addr) == A_MASK) |-> mask == $past(wdata[N_IN-1:0]));
endmodule

// File: rtl/hpm_chan.sv
module hpm_chan #(
    parameter int DLY_W = 4,
    parameter int WID_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic [DLY_W-1:0] dly,
    input  logic [WID_W-1:0] width,
    input  logic             mask,
    output logic             cond
);
    localparam int DEPTH = (1 << DLY_W) - 1;

    typedef struct packed {
        logic [DEPTH-1:0] sr;
        logic             prev;
        logic [WID_W:0]   cnt;
    } ch_t;

    ch_t ch_d, ch_q;
    logic [DEPTH:0] hist;
    logic tap, rise;

    always_comb begin
        hist = {ch_q.sr, hit};
        tap  = hist[dly];
        rise = tap & ~ch_q.prev;
        ch_d      = ch_q;
        ch_d.sr   = hist[DEPTH-1:0];
        ch_d.prev = tap;
        if (ch_q.cnt != '0)
            ch_d.cnt = ch_q.cnt - 1'b1;
        else if (rise)
            ch_d.cnt = {1'b0, width} + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= '0;
        else     ch_q <= ch_d;
    end

    assign cond = (ch_q.cnt != '0) & ~mask;

    // R4
    dead_time_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_q.cnt != '0 && rise) |=> ch_q.cnt == $past(ch_q.cnt) - 1'b1);
endmodule

// File: rtl/hpm_rate_scaler.sv
module hpm_rate_scaler #(
    parameter int N_IN  = 16,
    parameter int SEL_W = $clog2(N_IN),
    parameter int CNT_W = 8,
    parameter int TIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  hits,
    input  logic [SEL_W-1:0] sel,
    input  logic [TIM_W-1:0] win,
    output logic [CNT_W-1:0] rate
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [TIM_W-1:0] tim;
        logic [CNT_W-1:0] lat;
    } sc_t;

    sc_t sc_d, sc_q;
    logic pick, expire;
    logic [CNT_W-1:0] inc;

    always_comb begin
        pick   = hits[sel];
        expire = sc_q.tim >= win;
        inc    = (sc_q.cnt == MAXV) ? MAXV : sc_q.cnt + CNT_W'(pick & ~sc_q.prev);
        sc_d      = sc_q;
        sc_d.prev = pick;
        if (expire) begin
            sc_d.tim = '0;
            sc_d.lat = inc;
            sc_d.cnt = '0;
        end else begin
            sc_d.tim = sc_q.tim + 1'b1;
            sc_d.cnt = inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sc_q <= '0;
        else     sc_q <= sc_d;
    end

    assign rate = sc_q.lat;

    // R9
    window_restart_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> sc_q.tim == '0 && sc_q.cnt == '0);
    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_q.cnt == MAXV && !expire) |=> sc_q.cnt == MAXV);
endmodule

// File: rtl/hit_pad_merger.sv
module hit_pad_merger
    import hpm_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    parameter int DLY_W = 4,
    parameter int WID_W = 4,
    parameter int CNT_W = 8,
    parameter int TIM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   hit_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [N_OUT-1:0]  hit_out
);
    localparam int SEL_W = $clog2(N_IN);
    localparam int G2 = N_IN / N_OUT;
    localparam int G4 = 2 * G2;
    localparam int G8 = 4 * G2;

    logic [N_IN-1:0]            mask;
    grp_e                       mode;
    logic [WID_W-1:0]           width;
    logic [SEL_W-1:0]           sel;
    logic [TIM_W-1:0]           win;
    logic [N_IN-1:0][DLY_W-1:0] dly;
    logic [CNT_W-1:0]           rate;
    logic [N_IN-1:0]            cond;
    logic [N_OUT-1:0]           out_d, out_q;

    hpm_cfg_bank #(.N_IN(N_IN), .DLY_W(DLY_W), .WID_W(WID_W), .TIM_W(TIM_W),
                   .CNT_W(CNT_W), .SEL_W(SEL_W)) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .rate(rate), .mask(mask), .mode(mode), .width(width),
        .sel(sel), .win(win), .dly(dly)
    );

    for (genvar c = 0; c < N_IN; c++) begin : g_chan
        hpm_chan #(.DLY_W(DLY_W), .WID_W(WID_W)) chan_i (
            .clk(clk), .rst(rst), .hit(hit_in[c]), .dly(dly[c]), .width(width),
            .mask(mask[c]), .cond(cond[c])
        );
    end

    hpm_rate_scaler #(.N_IN(N_IN), .SEL_W(SEL_W), .CNT_W(CNT_W), .TIM_W(TIM_W)) scaler_i (
        .clk(clk), .rst(rst), .hits(hit_in), .sel(sel), .win(win), .rate(rate)
    );

    always_comb begin
        out_d = '0;
        case (mode)
            GRP_QUAD: for (int k = 0; k < N_IN / G4; k++) out_d[k] = |cond[k*G4 +: G4];
            GRP_OCT:  for (int k = 0; k < N_IN / G8; k++) out_d[k] = |cond[k*G8 +: G8];
            default:  for (int k = 0; k < N_OUT; k++)     out_d[k] = |cond[k*G2 +: G2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign hit_out = out_q;

    // R7
    quad_upper_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == GRP_QUAD) |-> hit_out[N_OUT-1:N_IN/G4] == '0);
    // R8
    oct_upper_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == GRP_OCT) |-> hit_out[N_OUT-1:N_IN/G8] == '0);
endmodule

// File: tb/hit_pad_merger_tb_top.sv
`timescale 1ns/1ps
module hit_pad_merger_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] hit_in = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [7:0]  hit_out;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    string cur_tag = "R6";

    always #4 clk = ~clk;

    hit_pad_merger dut_i (
        .clk(clk), .rst(rst), .hit_in(hit_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hit_out(hit_out)
    );

    // reference model state
    logic [15:0] m_mask;
    logic [1:0]  m_mode;
    logic [3:0]  m_width, m_sel;
    logic [15:0] m_win;
    logic [3:0]  m_dly [16];
    logic [14:0] m_sr [16];
    logic        m_prev [16];
    int          m_cnt [16];
    logic [7:0]  m_out;
    logic        s_prev;
    int          s_cnt, s_tim, s_lat;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] grp(logic [15:0] c, logic [1:0] m);
        logic [7:0] r = '0;
        if (m == 2'd1)      for (int k = 0; k < 4; k++) r[k] = |c[4*k +: 4];
        else if (m == 2'd2) for (int k = 0; k < 2; k++) r[k] = |c[8*k +: 8];
        else                for (int k = 0; k < 8; k++) r[k] = |c[2*k +: 2];
        return r;
    endfunction

    function automatic int exp_rd(logic [3:0] a);
        int r = 0;
        case (a)
            4'd0: r = m_mask;
            4'd1: r = m_mode;
            4'd2: r = m_width;
            4'd3: r = m_sel;
            4'd4: r = m_win;
            4'd5: r = s_lat;
            4'd8, 4'd9, 4'd10, 4'd11:
                for (int j = 0; j < 4; j++) r |= int'(m_dly[(a - 8) * 4 + j]) << (4 * j);
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic model_step();
        logic [15:0] cnd;
        logic [15:0] hist;
        logic tap, rise, pk;
        int inc;
        if (rst) begin
            m_mask = '0; m_mode = '0; m_width = '0; m_sel = '0; m_win = '0; m_out = '0;
            for (int c = 0; c < 16; c++) begin
                m_dly[c] = '0; m_sr[c] = '0; m_prev[c] = 1'b0; m_cnt[c] = 0;
            end
            s_prev = 1'b0; s_cnt = 0; s_tim = 0; s_lat = 0;
        end else begin
            for (int c = 0; c < 16; c++) cnd[c] = (m_cnt[c] != 0) && !m_mask[c];
            m_out = grp(cnd, m_mode);
            for (int c = 0; c < 16; c++) begin
                hist = {m_sr[c], hit_in[c]};
                tap = hist[m_dly[c]];
                rise = tap & ~m_prev[c];
                if (m_cnt[c] != 0) m_cnt[c]--;
                else if (rise) m_cnt[c] = m_width + 1;
                m_prev[c] = tap;
                m_sr[c] = hist[14:0];
            end
            pk = hit_in[m_sel];
            inc = (s_cnt == 255) ? 255 : s_cnt + int'(pk & ~s_prev);
            if (s_tim >= m_win) begin s_tim = 0; s_lat = inc; s_cnt = 0; end
            else begin s_tim++; s_cnt = inc; end
            s_prev = pk;
            if (cfg_we) begin
                case (cfg_addr)
                    4'd0: m_mask = cfg_wdata;
                    4'd1: m_mode = cfg_wdata[1:0];
                    4'd2: m_width = cfg_wdata[3:0];
                    4'd3: m_sel = cfg_wdata[3:0];
                    4'd4: m_win = cfg_wdata;
                    4'd8, 4'd9, 4'd10, 4'd11:
                        for (int j = 0; j < 4; j++) m_dly[(cfg_addr - 8) * 4 + j] = cfg_wdata[4*j +: 4];
                    default: ;
                endcase
            end
        end
    endtask

    always @(posedge clk) model_step();

    always @(negedge clk) begin
        if (cmp_en) begin
            #2;
            chk(cur_tag, hit_out, m_out);
        end
    end

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, int exp);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic idle(int n);
        hit_in = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_run(int n, logic [1:0] mode, string tag);
        cur_tag = tag;
        wr(4'd1, {14'd0, mode});
        wr(4'd0, 16'($urandom) & 16'($urandom));
        wr(4'd2, 16'($urandom % 4));
        for (int k = 0; k < 4; k++) wr(4'(8 + k), 16'($urandom));
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hit_in = 16'($urandom) & 16'($urandom) & 16'($urandom);
            rd_chk("R9", 4'd5, s_lat);
        end
        idle(24);
    endtask

    initial begin
        #1_600_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int a = 0; a < 16; a++) rd_chk("R1", 4'(a), 0);
        chk("R1", hit_out, 0);
        cmp_en = 1'b1;

        // R2: write and read back
        wr(4'd0, 16'hA5C3); rd_chk("R2", 4'd0, 16'hA5C3);
        wr(4'd4, 16'h1234); rd_chk("R2", 4'd4, 16'h1234);
        wr(4'd9, 16'hFEDC); rd_chk("R2", 4'd9, 16'hFEDC);
        wr(4'd2, 16'h0007); rd_chk("R2", 4'd2, 16'h0007);
        rd_chk("R2", 4'd7, 0);
        wr(4'd0, 16'h0000); wr(4'd2, 16'h0000); wr(4'd9, 16'h0000); wr(4'd4, 16'h0000);

        // R3: delay of 5 on input 0
        cur_tag = "R3";
        wr(4'd8, 16'h0005);
        idle(20);
        hit_in[0] = 1'b1;
        @(negedge clk);
        hit_in[0] = 1'b0;
        for (int j = 0; j < 9; j++) begin
            #1 chk("R3", hit_out[0], int'(j == 6));
            @(negedge clk);
        end
        wr(4'd8, 16'h0000);

        // R4: pulse length 4 cycles, second edge inside the pulse ignored
        cur_tag = "R4";
        wr(4'd2, 16'h0003);
        idle(20);
        hit_in[2] = 1'b1;
        @(negedge clk);
        hit_in[2] = 1'b0;
        for (int j = 0; j < 8; j++) begin
            if (j == 1) hit_in[2] = 1'b1;
            if (j == 3) hit_in[2] = 1'b0;
            #1 chk("R4", hit_out[1], int'(j >= 1 && j <= 4));
            @(negedge clk);
        end
        wr(4'd2, 16'h0000);

        // R5: all inputs suppressed
        cur_tag = "R5";
        wr(4'd0, 16'hFFFF);
        idle(20);
        hit_in = 16'hFFFF;
        for (int j = 0; j < 6; j++) begin
            #1 chk("R5", hit_out, 0);
            @(negedge clk);
            hit_in = ~hit_in;
        end
        idle(20);
        wr(4'd0, 16'h0000);

        rand_run(400, 2'd0, "R6");
        rand_run(300, 2'd3, "R6");
        rand_run(400, 2'd1, "R7");
        rand_run(400, 2'd2, "R8");
        rand_run(300, 2'd0, "R5");

        // R9: rate monitor on input 3, window 50 cycles
        wr(4'd3, 16'd3);
        wr(4'd4, 16'd49);
        rand_run(600, 2'd0, "R9");

        // R10: saturation with an edge every two cycles over 1000-cycle windows
        cur_tag = "R10";
        wr(4'd4, 16'd999);
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            hit_in = {12'd0, ~hit_in[3], 3'd0};
        end
        idle(2);
        rd_chk("R10", 4'd5, 255);
        rd_chk("R10", 4'd5, s_lat);

        cmp_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule